// File: doc/BRIEF.md
# Machine-Cycle Timebase and Reset Sequencer

This block produces the state and phase timing of a small 8-bit controller core. A machine cycle has six states, S1 to S6, and each state has two phases, P1 and P2. The counter advances one phase on every oscillator clock, so one machine cycle takes twelve clocks. The block also owns the external reset pin, which is active high. The pin passes through a two-flop synchronizer. The result is looked at only once per machine cycle, at the end of S5P2. That one sample decides whether the core enters an internal reset procedure, stays in it, or is released.

While the procedure runs, the block holds the core in reset and presets the port latches to all ones. It also holds ALE high and keeps the address drivers off. The procedure lasts two full machine cycles and ends with a one-clock strobe that says every register now holds its default value. Release is only recognised at a later sample slot. The restart follows a fixed sequence. Address output starts at the next S5P1, and the first ALE falling edge comes one phase later, at S5P2. After that, ALE pulses twice in every machine cycle.

The chip power-on reset `rst_n` is separate from the reset pin. It is asynchronous and active low. It restarts the timebase at S1P1 and begins a fresh reset procedure.

Top module: `cyc_reset_sequencer`

## Requirements
- R1: While `rst_n` is high, the timebase advances one phase per clock in the order S1P1, S1P2, S2P1 … S6P2 and then wraps to S1P1. `state` shows the state number minus one (0 to 5), and `phase` is 0 for P1 and 1 for P2.
- R2: `rst_pin` reaches the sequencer through a two-flop synchronizer. It is evaluated only at the clock edge that ends S5P2, where the decision uses the pin level captured two rising edges earlier. A pulse that does not cover a sample has no effect on any output.
- R3: If a sample finds the pin high while the core is running, then from the next clock (S6P1) `core_rst` and `port_preset` are high, `addr_en` is low and `ale` is high.
- R4: The procedure spans two machine cycles. `regs_dflt` pulses high for exactly one clock, in the S6P1 that follows the second sample after entry. There is no further pulse while the pin stays high.
- R5: Release happens only at a sample where the procedure has completed and the pin is seen low. A pulse caught by a single sample still gets the full procedure. While the pin stays high, the core stays in reset.
- R6: After release, `port_preset` drops at S6P1. `core_rst` stays high until the next S5P1. From S5P1 on, `core_rst` is low and `addr_en` equals `ext_prog`.
- R7: `ale` is high whenever `core_rst` is high. While running, `ale` is high in S1P1, S1P2, S2P1, S4P1, S4P2 and S5P1 and low in all other slots. This gives falling edges at S2P2 and S5P2, and the first falling edge is at S5P2, directly after address output starts.
- R8: With `ext_prog` low, `addr_en` stays low at all times.
- R9: Count the rising edges from the first edge that sees `rst_pin` low to the first clock with `ale` low after release. The count is k + 12, where k is the number of slots from the slot in force when the pin drops up to the next S5P2 sample at least two edges away. This puts it between one machine cycle and two machine cycles plus the two synchronizer clocks.
- R10: While `rst_n` is low and right after it rises, the timebase is at S1P1 with `core_rst`, `port_preset` and `ale` high and `addr_en` and `regs_dflt` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per cycle |
| rst_n | input | 1 | Chip power-on reset, asynchronous, active low |
| rst_pin | input | 1 | Raw external reset pin, active high, asynchronous |
| ext_prog | input | 1 | High when program memory is external |
| state | output | 3 | Current state, 0 = S1 … 5 = S6 |
| phase | output | 1 | Current phase, 0 = P1, 1 = P2 |
| core_rst | output | 1 | Core held in reset |
| regs_dflt | output | 1 | One-clock strobe: registers at default values |
| port_preset | output | 1 | Drive all port latches to ones |
| addr_en | output | 1 | Address output enable |
| ale | output | 1 | Address latch enable pin |

## Verification
The bench sweeps the clock slot at which the reset pin rises across all twelve positions, for pulse lengths from one clock to several machine cycles, and runs each case with external program memory both on and off. Short pulses expose a sequencer that samples on every clock instead of once per cycle, since it would react to pulses that miss the sample slot. They also expose one that releases before the two-cycle procedure is done. Long holds catch a design that repeats the defaults strobe or leaves reset while the pin is still high. For every release slot, the bench measures the exact clock count from pin release to the first ALE fall, so a sequencer that starts the address at the wrong slot or leaves out the synchronizer delay is off by a known amount.

// File: rtl/cyc_pkg.sv
`timescale 1ns/1ps
package cyc_pkg;

  // Sequencer operating mode
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,   // core executing
    MODE_RESET = 2'd1,   // internal reset procedure / hold
    MODE_WAKE  = 2'd2    // released, waiting for address start slot
  } seq_mode_t;

endpackage

// File: rtl/cyc_timebase.sv
`timescale 1ns/1ps
module cyc_timebase #(
  parameter int N_STATES = 6,
  parameter int N_PHASES = 2,
  localparam int ST_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int PH_W   = (N_PHASES > 1) ? $clog2(N_PHASES) : 1,
  localparam int SLOT_W = $clog2(N_STATES * N_PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ST_W-1:0]   state_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic [ST_W-1:0] state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            phase_wrap;
  logic            state_wrap;

  // next-state
  always_comb begin
    phase_wrap = (phase_q == PH_W'(N_PHASES - 1));
    state_wrap = (state_q == ST_W'(N_STATES - 1));
    phase_d    = phase_wrap ? '0 : phase_q + 1'b1;
    state_d    = state_q;
    if (phase_wrap) begin
      state_d = state_wrap ? '0 : state_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign slot_o  = SLOT_W'(state_q) * SLOT_W'(N_PHASES) + SLOT_W'(phase_q);

endmodule

// File: rtl/cyc_pin_sync.sv
`timescale 1ns/1ps
module cyc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/cyc_reset_fsm.sv
`timescale 1ns/1ps
module cyc_reset_fsm
  import cyc_pkg::*;
#(
  parameter int RST_CYCLES   = 2,
  parameter int SLOT_W       = 4,
  parameter int SMP_SLOT     = 9,
  parameter int WAKE_END     = 7,
  localparam int CNT_W       = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              pin_sync_i,
  output seq_mode_t         mode_o,
  output logic              dflt_o
);

  localparam logic [CNT_W-1:0] DONE     = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RST_CYCLES - 1);

  seq_mode_t        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             dflt_q, dflt_d;
  logic             smp_en;
  logic             wake_en;

  // next-state
  always_comb begin
    smp_en  = (slot_i == SLOT_W'(SMP_SLOT));
    wake_en = (slot_i == SLOT_W'(WAKE_END));
    cnt_inc = (cnt_q == DONE) ? cnt_q : cnt_q + 1'b1;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    dflt_d  = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (smp_en && pin_sync_i) begin
          mode_d = MODE_RESET;
          cnt_d  = '0;
        end
      end
      MODE_RESET: begin
        if (smp_en) begin
          cnt_d = cnt_inc;
          if (cnt_q == LAST_CNT) dflt_d = 1'b1;
          if ((cnt_inc == DONE) && !pin_sync_i) mode_d = MODE_WAKE;
        end
      end
      MODE_WAKE: begin
        if (wake_en) mode_d = MODE_RUN;
      end
      default: begin
        mode_d = MODE_RESET;
        cnt_d  = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      cnt_q  <= '0;
      dflt_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      dflt_q <= dflt_d;
    end
  end

  assign mode_o = mode_q;
  assign dflt_o = dflt_q;

endmodule

// File: rtl/cyc_bus_strobes.sv
`timescale 1ns/1ps
module cyc_bus_strobes
  import cyc_pkg::*;
#(
  parameter int SLOTS     = 12,
  parameter int SLOT_W    = 4,
  parameter int ALE_START = 6,
  parameter int ALE_LEN   = 3,
  localparam int HALF     = SLOTS / 2,
  localparam int MAP_N    = 2 ** SLOT_W
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  seq_mode_t         mode_i,
  input  logic              ext_prog_i,
  output logic              ale_o,
  output logic              addr_en_o,
  output logic              core_rst_o,
  output logic              port_preset_o
);

  logic [MAP_N-1:0] ale_map;
  logic             running;

  // ALE high window per slot, repeated every half machine cycle
  generate
    for (genvar g = 0; g < MAP_N; g++) begin : g_ale_map
      if (g < SLOTS) begin : g_live
        assign ale_map[g] = (((g + SLOTS - ALE_START) % HALF) < ALE_LEN);
      end else begin : g_pad
        assign ale_map[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    running       = (mode_i == MODE_RUN);
    core_rst_o    = !running;
    port_preset_o = (mode_i == MODE_RESET);
    addr_en_o     = running && ext_prog_i;
    ale_o         = !running || ale_map[slot_i];
  end

endmodule

// File: rtl/cyc_reset_sequencer.sv
`timescale 1ns/1ps
module cyc_reset_sequencer
  import cyc_pkg::*;
#(
  parameter int N_STATES    = 6,
  parameter int N_PHASES    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 2,
  parameter int SMP_STATE   = 4,
  parameter int SMP_PHASE   = 1,
  parameter int ALE_LEN     = 3,
  localparam int ST_W       = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int PH_W       = (N_PHASES > 1) ? $clog2(N_PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            ext_prog,
  output logic [ST_W-1:0] state,
  output logic [PH_W-1:0] phase,
  output logic            core_rst,
  output logic            regs_dflt,
  output logic            port_preset,
  output logic            addr_en,
  output logic            ale
);

  localparam int SLOTS     = N_STATES * N_PHASES;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int SMP_SLOT  = SMP_STATE * N_PHASES + SMP_PHASE;
  localparam int ADR_SLOT  = SMP_SLOT - 1;          // address start, one phase before sample
  localparam int WAKE_END  = ADR_SLOT - 1;          // last slot before address start
  localparam int ALE_START = ADR_SLOT - (ALE_LEN - 1);

  logic [SLOT_W-1:0] slot;
  logic              pin_sync;
  seq_mode_t         mode;

  cyc_timebase #(
    .N_STATES (N_STATES),
    .N_PHASES (N_PHASES)
  ) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (state),
    .phase_o (phase),
    .slot_o  (slot)
  );

  cyc_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (rst_pin),
    .sync_o (pin_sync)
  );

  cyc_reset_fsm #(
    .RST_CYCLES (RST_CYCLES),
    .SLOT_W     (SLOT_W),
    .SMP_SLOT   (SMP_SLOT),
    .WAKE_END   (WAKE_END)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_i     (slot),
    .pin_sync_i (pin_sync),
    .mode_o     (mode),
    .dflt_o     (regs_dflt)
  );

  cyc_bus_strobes #(
    .SLOTS     (SLOTS),
    .SLOT_W    (SLOT_W),
    .ALE_START (ALE_START),
    .ALE_LEN   (ALE_LEN)
  ) u_strb (
    .slot_i        (slot),
    .mode_i        (mode),
    .ext_prog_i    (ext_prog),
    .ale_o         (ale),
    .addr_en_o     (addr_en),
    .core_rst_o    (core_rst),
    .port_preset_o (port_preset)
  );

endmodule

// File: rtl/cyc_reset_sequencer_chk.sv
`timescale 1ns/1ps
module cyc_reset_sequencer_chk #(
  parameter int N_STATES  = 6,
  parameter int SMP_STATE = 4,
  parameter int ST_W      = 3,
  parameter int PH_W      = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_pin,
  input logic            ext_prog,
  input logic [ST_W-1:0] state,
  input logic [PH_W-1:0] phase,
  input logic            core_rst,
  input logic            regs_dflt,
  input logic            port_preset,
  input logic            addr_en,
  input logic            ale
);

  localparam logic [ST_W-1:0] LAST_ST  = ST_W'(N_STATES - 1);
  localparam logic [ST_W-1:0] SMP_ST   = ST_W'(SMP_STATE);
  localparam logic [ST_W-1:0] AFTER_ST = ST_W'(SMP_STATE + 1);

  p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |=> (phase == PH_W'(1)) && $stable(state));

  p_state_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_W'(1)) |=> (phase == '0) &&
      (state == (($past(state) == LAST_ST) ? '0 : $past(state) + 1'b1)));

  p_enter_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_preset) |-> (state == AFTER_ST) && (phase == '0));

  p_preset_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    port_preset |-> core_rst && ale && !addr_en);

  p_dflt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_dflt |=> !regs_dflt);

  p_dflt_in_rst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    regs_dflt |-> core_rst && (state == AFTER_ST) && (phase == '0));

  p_release_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_preset) |-> core_rst && (state == AFTER_ST) && (phase == '0));

  p_addr_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (state == SMP_ST) && (phase == '0));

  p_addr_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> !core_rst);

  p_first_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |=> !ale);

  p_ale_in_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> ale);

  p_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_prog |-> !addr_en);

endmodule

bind cyc_reset_sequencer cyc_reset_sequencer_chk u_chk (.*);

// File: tb/sim_cyc_reset_sequencer.sv
`timescale 1ns/1ps
module sim_cyc_reset_sequencer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rst_pin;
  logic       ext_prog;
  logic [2:0] state;
  logic [0:0] phase;
  logic       core_rst, regs_dflt, port_preset, addr_en, ale;

  always #2.5 clk = ~clk;   // 200 MHz

  cyc_reset_sequencer u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_pin     (rst_pin),
    .ext_prog    (ext_prog),
    .state       (state),
    .phase       (phase),
    .core_rst    (core_rst),
    .regs_dflt   (regs_dflt),
    .port_preset (port_preset),
    .addr_en     (addr_en),
    .ale         (ale)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  // expectation model built from the requirements: mode 0 run, 1 reset, 2 wake
  int m_slot, m_mode, m_cnt;
  bit p1, p2, m_dflt;

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // R7: run-time ALE high in slots 0,1,2 and 6,7,8
  function automatic int ale_slot(input int sl);
    return ((sl % 6) < 3) ? 1 : 0;
  endfunction

  task automatic model_edge();
    bit s;
    s = p2;                       // R2: level captured two edges earlier
    m_dflt = 0;
    if (m_slot == 9) begin        // S5P2 sample
      if (m_mode == 0 && s) begin
        m_mode = 1; m_cnt = 0;
      end else if (m_mode == 1) begin
        if (m_cnt == 1) m_dflt = 1;
        if (m_cnt < 2) m_cnt++;
        if (m_cnt == 2 && !s) m_mode = 2;
      end
    end else if (m_slot == 7 && m_mode == 2) begin
      m_mode = 0;
    end
    p2 = p1;
    p1 = rst_pin;
    m_slot = (m_slot + 1) % 12;
  endtask

  task automatic compare();
    check("R1", int'(state), m_slot / 2);
    check("R1", int'(phase), m_slot % 2);
    check("R2,R5", int'(core_rst), (m_mode != 0) ? 1 : 0);
    check("R3", int'(port_preset), (m_mode == 1) ? 1 : 0);
    check("R4", int'(regs_dflt), int'(m_dflt));
    check(ext_prog ? "R6" : "R8", int'(addr_en), (m_mode == 0 && ext_prog) ? 1 : 0);
    check("R7", int'(ale), (m_mode != 0) ? 1 : ale_slot(m_slot));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; ext_prog = 1'b1;
    m_slot = 0; m_mode = 1; m_cnt = 0; p1 = 0; p2 = 0; m_dflt = 0;
    repeat (3) @(negedge clk);
    check("R10", int'(core_rst), 1);
    check("R10", int'(port_preset), 1);
    check("R10", int'(ale), 1);
    rst_n = 1'b1;
    #0.1;
    check("R10", int'(state), 0);
    check("R10", int'(phase), 0);
    check("R10", int'(addr_en), 0);
    check("R10", int'(regs_dflt), 0);

    for (int ep = 1; ep >= 0; ep--) begin
      ext_prog = ep[0];
      for (int off = 0; off < 12; off++) begin
        for (int li = 0; li < 6; li++) begin
          int len;
          int guard;
          len = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 5 :
                (li == 3) ? 13 : (li == 4) ? 40 : 75;
          guard = 0;
          while (core_rst && guard < 100) begin tick(); guard++; end
          while ((int'(state) * 2 + int'(phase)) != off) tick();
          rst_pin = 1'b1;
          for (int t = 0; t < len; t++) tick();
          if (len >= 40) begin
            int sl, k, d;
            sl = int'(state) * 2 + int'(phase);
            k = (9 - sl + 12) % 12;
            if (k < 2) k += 12;
            rst_pin = 1'b0;
            d = 0;
            do begin tick(); d++; end while (!(core_rst == 1'b0 && ale == 1'b0) && d < 60);
            check("R9", d, k + 12);
            check("R9", (d >= 12 && d < 26) ? 1 : 0, 1);
          end else begin
            rst_pin = 1'b0;
          end
          for (int t = 0; t < 40; t++) tick();
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule